// File: doc/BRIEF.md
# Serial port bit-clock generator

This block produces all bit-rate timing for a serial transceiver that works either asynchronously, with an oversampled receiver, or synchronously, with a shared serial clock. A single 12-bit programmable down-counter sets the rate. In asynchronous operation each expiry of that counter is one oversampling tick. A bit lasts 16 ticks, or 8 ticks when the double-rate select is set. In synchronous operation the counter instead toggles a serial clock that the block drives as master. As slave, the block follows an external serial clock through a two-stage synchronizer and an edge detector.

The transmitter and receiver take their timing from one-cycle strobes only. These are a transmit clock enable, a receive clock enable, an oversampling tick, and in synchronous modes a "change transmit data" strobe and a "sample receive data" strobe. The two synchronous strobes always fall on opposite serial-clock edges: transmit data changes on the rising edge and receive data is sampled on the falling edge.

The divisor is watched for changes. A new value restarts the count at once, so the new rate applies without waiting for the old period to finish. Frame formatting and data handling belong to the neighbouring blocks.

Top module: `usart_clkgen`

## Requirements
- R1: Asynchronous mode with `dbl_speed`=0, divisor D. `os_tick` pulses for one cycle every D+1 clock cycles. `rx_clk_en` equals `os_tick`. `tx_clk_en` pulses on every 16th `os_tick`, coinciding with that tick.
- R2: Asynchronous mode with `dbl_speed`=1. `tx_clk_en` pulses on every 8th `os_tick`, and `os_tick` keeps the period D+1.
- R3: Synchronous master (`sync_mode`=1, `master_sel`=1). `sck_oe`=1, and `sck_out` toggles every D+1 cycles, giving a period of 2(D+1) cycles at 50% duty.
- R4: Synchronous master strobes. `tx_change` is high for exactly the one cycle in which `sck_out` has just risen. `rx_sample` is high for exactly the one cycle in which `sck_out` has just fallen. `tx_clk_en` equals `tx_change` and `rx_clk_en` equals `rx_sample`.
- R5: In both synchronous modes `dbl_speed` has no effect on any output.
- R6: Synchronous slave (`sync_mode`=1, `master_sel`=0). `sck_oe`=0 and `sck_out`=0. A level of `sck_in` present at clock edge k produces the edge strobe in the cycle after edge k+1, which is two cycles of latency. A rising edge gives `tx_change` and a falling edge gives `rx_sample`, each one cycle wide. The divisor has no effect.
- R7: In asynchronous mode `tx_change` and `rx_sample` stay low. In synchronous modes `os_tick` stays low.
- R8: While `rst_n`=0 all strobes and `sck_out` are low. After release, the first divider strobe appears in the cycle after the (D+2)th clock edge.
- R9: Changing `divisor` to D' reloads the counter. The next divider strobe appears in the cycle after the (D'+2)th clock edge following the change, and the strobes then repeat every D'+1 cycles.
- R10: The divisor extremes work: D=0 gives a strobe every cycle, and D=4095 gives a period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 12 | Rate divisor D (0 to 4095) |
| dbl_speed | input | 1 | Asynchronous double rate (8 ticks per bit) |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| master_sel | input | 1 | In synchronous mode: 1 = drive serial clock, 0 = follow it |
| sck_in | input | 1 | External serial clock (slave) |
| sck_out | output | 1 | Driven serial clock (master) |
| sck_oe | output | 1 | Serial clock pin output enable |
| os_tick | output | 1 | Receiver oversampling tick (asynchronous) |
| tx_clk_en | output | 1 | Transmitter bit clock enable |
| rx_clk_en | output | 1 | Receiver clock enable |
| tx_change | output | 1 | Change transmit data strobe (synchronous) |
| rx_sample | output | 1 | Sample receive data strobe (synchronous) |

## Verification
A corrupted down-counter or a missed reload shows up as a wrong interval between consecutive `os_tick` pulses or `sck_out` toggles within one divider period, or as a wrong first-strobe delay after reset or after a divisor change. A bit-phase counter that drifts misplaces `tx_clk_en` relative to the 8th or 16th tick within one bit time. A broken synchronizer or edge-detector history shifts or doubles `tx_change` and `rx_sample` within two to three cycles of each `sck_in` edge. A swapped edge polarity is visible at the first master toggle.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;
  typedef enum logic [1:0] {
    MODE_ASYNC_X1    = 2'd0,
    MODE_ASYNC_X2    = 2'd1,
    MODE_SYNC_MASTER = 2'd2,
    MODE_SYNC_SLAVE  = 2'd3
  } clk_mode_e;
endpackage

// File: rtl/ucg_divider.sv
module ucg_divider #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             expire,
  output logic             reload
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q;
  logic             primed_q, primed_d;

  // reload on first enabled cycle or whenever the divisor value moves
  assign reload = run && (!primed_q || (divisor != div_q));
  assign expire = run && !reload && (cnt_q == '0);

  always_comb begin
    cnt_d    = cnt_q;
    primed_d = primed_q;
    if (!run) begin
      cnt_d    = '0;
      primed_d = 1'b0;
    end else if (reload) begin
      cnt_d    = divisor;
      primed_d = 1'b1;
    end else if (cnt_q == '0) begin
      cnt_d = divisor;
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
      div_q    <= '0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
      div_q    <= divisor;
    end
  end
endmodule

// File: rtl/ucg_bitphase.sv
module ucg_bitphase #(
  parameter int OS_NORM = 16,
  parameter int OS_DBL  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  input  logic dbl,
  output logic bit_done
);
  localparam int PH_W = $clog2(OS_NORM);
  localparam logic [PH_W-1:0] LIM_NORM = PH_W'(OS_NORM - 1);
  localparam logic [PH_W-1:0] LIM_DBL  = PH_W'(OS_DBL - 1);

  logic [PH_W-1:0] ph_q, ph_d;
  logic [PH_W-1:0] lim;

  assign lim      = dbl ? LIM_DBL : LIM_NORM;
  assign bit_done = tick && !clear && (ph_q >= lim);

  always_comb begin
    ph_d = ph_q;
    if (clear)         ph_d = '0;
    else if (bit_done) ph_d = '0;
    else if (tick)     ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/ucg_master_sck.sv
module ucg_master_sck (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic expire,
  output logic sck_q,
  output logic rise_q,
  output logic fall_q
);
  logic sck_d, rise_d, fall_d;

  always_comb begin
    sck_d  = sck_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (!active) begin
      sck_d = 1'b0;
    end else if (expire) begin
      sck_d  = ~sck_q;
      rise_d = ~sck_q;
      fall_d = sck_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      sck_q  <= sck_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end
endmodule

// File: rtl/ucg_slave_edge.sv
module ucg_slave_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic                   level;

  assign level = sync_q[SYNC_STAGES-1];
  assign rise  = level && !prev_q;
  assign fall  = !level && prev_q;

  always_comb begin
    for (int i = 0; i < SYNC_STAGES; i++) begin
      sync_d[i] = (i == 0) ? pin : sync_q[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= level;
    end
  end
endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
  import usart_clkgen_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int OS_NORM     = 16,
  parameter int OS_DBL      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             dbl_speed,
  input  logic             sync_mode,
  input  logic             master_sel,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             os_tick,
  output logic             tx_clk_en,
  output logic             rx_clk_en,
  output logic             tx_change,
  output logic             rx_sample
);
  clk_mode_e mode;
  logic is_async, is_master, is_slave;
  logic div_expire, div_reload, bit_done;
  logic m_sck, m_rise, m_fall, s_rise, s_fall;
  logic os_q, os_d, txb_q, txb_d;

  always_comb begin
    if (!sync_mode)      mode = dbl_speed ? MODE_ASYNC_X2 : MODE_ASYNC_X1;
    else if (master_sel) mode = MODE_SYNC_MASTER;
    else                 mode = MODE_SYNC_SLAVE;
  end

  assign is_async  = (mode == MODE_ASYNC_X1) || (mode == MODE_ASYNC_X2);
  assign is_master = (mode == MODE_SYNC_MASTER);
  assign is_slave  = (mode == MODE_SYNC_SLAVE);

  ucg_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!is_slave),
    .divisor (divisor),
    .expire  (div_expire),
    .reload  (div_reload)
  );

  ucg_bitphase #(.OS_NORM(OS_NORM), .OS_DBL(OS_DBL)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (div_reload || !is_async),
    .tick     (div_expire),
    .dbl      (mode == MODE_ASYNC_X2),
    .bit_done (bit_done)
  );

  ucg_master_sck u_msck (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (is_master),
    .expire (div_expire),
    .sck_q  (m_sck),
    .rise_q (m_rise),
    .fall_q (m_fall)
  );

  ucg_slave_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sedge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (sck_in),
    .rise  (s_rise),
    .fall  (s_fall)
  );

  // oversampling tick and bit enable, registered in step with master strobes
  always_comb begin
    os_d  = is_async && div_expire;
    txb_d = is_async && bit_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_q  <= 1'b0;
      txb_q <= 1'b0;
    end else begin
      os_q  <= os_d;
      txb_q <= txb_d;
    end
  end

  always_comb begin
    sck_oe    = is_master;
    sck_out   = is_master && m_sck;
    os_tick   = is_async && os_q;
    tx_change = (is_master && m_rise) || (is_slave && s_rise);
    rx_sample = (is_master && m_fall) || (is_slave && s_fall);
    tx_clk_en = is_async ? (txb_q && os_q) : tx_change;
    rx_clk_en = is_async ? os_q : rx_sample;
  end
endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_mode,
  input logic master_sel,
  input logic sck_out,
  input logic sck_oe,
  input logic os_tick,
  input logic tx_change,
  input logic rx_sample
);
  // R7: no synchronous strobes while asynchronous
  a_r7_async_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> (!tx_change && !rx_sample));

  // R7: no oversampling tick while synchronous
  a_r7_sync_no_os: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> !os_tick);

  // R4: transmit change strobe only on a fresh rising serial clock
  a_r4_tx_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && $past(sck_oe) && tx_change) |-> (sck_out && !$past(sck_out)));

  // R4: receive sample strobe only on a fresh falling serial clock
  a_r4_rx_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && $past(sck_oe) && rx_sample) |-> (!sck_out && $past(sck_out)));

  // R4: the two strobes never coincide
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_change, rx_sample}));

  // R3: every master clock toggle is accompanied by a strobe
  a_r3_toggle_strobed: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && $past(sck_oe) && (sck_out != $past(sck_out))) |-> (tx_change || rx_sample));

  // R6: slave never drives the serial clock
  a_r6_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !master_sel) |-> (!sck_oe && !sck_out));
endmodule

bind usart_clkgen usart_clkgen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_mode  (sync_mode),
  .master_sel (master_sel),
  .sck_out    (sck_out),
  .sck_oe     (sck_oe),
  .os_tick    (os_tick),
  .tx_change  (tx_change),
  .rx_sample  (rx_sample)
);

// File: tb/usart_clkgen_test.sv
module usart_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] divisor = '0;
  logic        dbl_speed = 1'b0;
  logic        sync_mode = 1'b0;
  logic        master_sel = 1'b0;
  logic        sck_in = 1'b0;
  logic        sck_out, sck_oe, os_tick, tx_clk_en, rx_clk_en, tx_change, rx_sample;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  usart_clkgen uut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .dbl_speed(dbl_speed),
    .sync_mode(sync_mode), .master_sel(master_sel), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .os_tick(os_tick),
    .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en),
    .tx_change(tx_change), .rx_sample(rx_sample)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected < 190000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int strobes_now();
    return int'(os_tick) + int'(tx_clk_en) + int'(rx_clk_en) +
           int'(tx_change) + int'(rx_sample) + int'(sck_out);
  endfunction

  task automatic do_reset(input bit check_idle);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    if (check_idle)
      chk(strobes_now() == 0, "R8", "outputs active during reset", strobes_now(), 0);
    rst_n = 1'b1;
  endtask

  // asynchronous run: nbits bit times after reset
  task automatic run_async(input int d, input bit dbl, input int nbits);
    int ratio = dbl ? 8 : 16;
    int len   = (d + 2) + (d + 1) * (ratio * nbits - 1);
    int first = 0, last = 0, bad_os = 0, bad_tx = 0, bad_misc = 0;
    int n_tx = 0, since = 0;
    string rq = dbl ? "R2" : "R1";
    divisor = 12'(d); dbl_speed = dbl; sync_mode = 1'b0;
    master_sel = 1'($urandom_range(1, 0));
    do_reset(1'b0);
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (os_tick) begin
        if (first == 0) first = i;
        else if (i - last != d + 1) bad_os++;
        last = i;
        since++;
      end
      if (tx_clk_en) begin
        if (!os_tick || since != ratio) bad_tx++;
        since = 0;
        n_tx++;
      end
      if (rx_clk_en != os_tick || tx_change || rx_sample || sck_oe || sck_out) bad_misc++;
    end
    chk(first == d + 2, "R8", "first tick after reset", first, d + 2);
    chk(bad_os == 0, (d == 0 || d == 4095) ? "R10" : rq, "tick interval errors", bad_os, 0);
    chk(bad_tx == 0, rq, "bit enable placement errors", bad_tx, 0);
    chk(n_tx == nbits, rq, "bit enable count", n_tx, nbits);
    chk(bad_misc == 0, "R7", "async side-output errors", bad_misc, 0);
  endtask

  task automatic run_master(input int d, input bit dbl, input int ntog);
    int len = (d + 2) + (d + 1) * (ntog - 1);
    int first = 0, last = 0, n_tog = 0, bad_per = 0, bad_stb = 0, bad_misc = 0;
    bit prev = 1'b0;
    divisor = 12'(d); dbl_speed = dbl; sync_mode = 1'b1; master_sel = 1'b1;
    do_reset(1'b0);
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (sck_out != prev) begin
        if (first == 0) first = i;
        else if (i - last != d + 1) bad_per++;
        last = i;
        n_tog++;
        if (sck_out && !(tx_change && !rx_sample)) bad_stb++;
        if (!sck_out && !(rx_sample && !tx_change)) bad_stb++;
      end else if (tx_change || rx_sample) bad_stb++;
      if (tx_clk_en != tx_change || rx_clk_en != rx_sample) bad_stb++;
      if (os_tick || !sck_oe) bad_misc++;
      prev = sck_out;
    end
    chk(first == d + 2, "R8", "first master toggle", first, d + 2);
    chk(bad_per == 0, "R3", "half period errors", bad_per, 0);
    chk(n_tog == ntog, dbl ? "R5" : "R3", "toggle count", n_tog, ntog);
    chk(bad_stb == 0, "R4", "edge strobe errors", bad_stb, 0);
    chk(bad_misc == 0, "R7", "os_tick or sck_oe wrong in master", bad_misc, 0);
  endtask

  task automatic run_slave(input bit dbl, input int nhalf);
    bit h0 = 1'b0, h1 = 1'b0, h2 = 1'b0, lvl = 1'b0;
    int hold = 4, n_half = 0, bad_r = 0, bad_f = 0, bad_misc = 0;
    int n_r = 0, exp_r = 0;
    divisor = 12'($urandom_range(20, 0)); dbl_speed = dbl;
    sync_mode = 1'b1; master_sel = 1'b0; sck_in = 1'b0;
    do_reset(1'b0);
    while (n_half < nhalf || hold > -4) begin
      @(negedge clk);
      if (tx_change != (h1 && !h2)) bad_r++;
      if (rx_sample != (!h1 && h2)) bad_f++;
      if (tx_change) n_r++;
      if (tx_clk_en != tx_change || rx_clk_en != rx_sample) bad_misc++;
      if (sck_oe || sck_out || os_tick) bad_misc++;
      if (($urandom_range(15, 0)) == 0) divisor = 12'($urandom_range(4095, 0));
      hold--;
      if (hold == 0 && n_half < nhalf) begin
        lvl = ~lvl;
        if (lvl) exp_r++;
        n_half++;
        hold = $urandom_range(6, 3);
      end
      sck_in = lvl;
      h2 = h1; h1 = h0; h0 = lvl;
    end
    chk(bad_r == 0, dbl ? "R5" : "R6", "rise strobe timing errors", bad_r, 0);
    chk(bad_f == 0, "R6", "fall strobe timing errors", bad_f, 0);
    chk(n_r == exp_r, "R6", "rise strobe count", n_r, exp_r);
    chk(bad_misc == 0, "R6", "slave output errors", bad_misc, 0);
  endtask

  task automatic run_reload(input int d1, input int d2, input int wait_c);
    int first = 0, second = 0;
    divisor = 12'(d1); dbl_speed = 1'b0; sync_mode = 1'b0; master_sel = 1'b0;
    do_reset(1'b0);
    repeat (wait_c) @(negedge clk);
    divisor = 12'(d2);
    for (int i = 1; i <= 2 * d2 + 6; i++) begin
      @(negedge clk);
      if (os_tick) begin
        if (first == 0) first = i;
        else if (second == 0) second = i;
      end
    end
    chk(first == d2 + 2, "R9", "first tick after divisor change", first, d2 + 2);
    chk(second - first == d2 + 1, "R9", "interval after divisor change", second - first, d2 + 1);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7301);
    do_reset(1'b1);
    @(negedge clk);
    chk(strobes_now() == 0, "R8", "outputs one cycle after release", strobes_now(), 0);
    // directed corners
    run_async(0, 1'b0, 3);
    run_async(0, 1'b1, 3);
    run_async(4095, 1'b1, 1);
    run_master(0, 1'b0, 8);
    run_master(5, 1'b1, 8);
    run_slave(1'b0, 12);
    run_slave(1'b1, 12);
    run_reload(40, 3, 10);
    run_reload(2, 9, 1);
    // random configurations
    for (int k = 0; k < 6; k++) begin
      int d = $urandom_range(15, 0);
      bit b = 1'($urandom_range(1, 0));
      case ($urandom_range(2, 0))
        0: run_async(d, b, 2);
        1: run_master(d, b, 6 + $urandom_range(4, 0));
        default: run_slave(b, 8 + $urandom_range(8, 0));
      endcase
    end
    for (int k = 0; k < 3; k++)
      run_reload(6 + $urandom_range(30, 0), $urandom_range(12, 0), $urandom_range(5, 1));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule